// File: doc/BRIEF.md
# Endianness Byte-Lane Mapper

The block sits between a load/store unit that thinks in logical byte addresses and values, and a memory port that is organised as physical byte lanes of one data word. For each access it takes a byte-order model, a logical address, an access size and, for stores, a right-justified value. From these it produces the word address, the physical byte enables and the store data steered into the correct lanes. For loads it records the lane plan of the request. It then assembles the value from the physical word that the memory returns on the next cycle.

Three byte-order models are supported. In little-endian, the lane of a byte equals the low address bits, and the lowest address carries the least significant byte. In byte-invariant big-endian, the lanes are the same as in little-endian, but the lowest address carries the most significant byte. In word-invariant big-endian, the low address bits are XOR-ed with the lane count minus one before a lane is chosen, and values are also combined most-significant-first. Splitting of accesses that cross a word and alignment fault checks are left to the requester. Every access must fit inside one data word.

Top module: `endian_lane_mapper`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_be` is zero when `req_valid` is low, `rsp_valid` is low and `rsp_rdata` is zero.
- R2: `mem_addr` equals `req_addr` with its low log2(lanes) bits cleared. The `req_mode` codes are 0 = little-endian, 1 = byte-invariant big-endian, and 2 or 3 = word-invariant big-endian (code 3 acts exactly like code 2).
- R3: A logical byte at address A uses physical lane A[1:0] in modes 0 and 1, and lane A[1:0] XOR 3 in modes 2 and 3. Lane k is bits 8k+7..8k of `mem_wdata`/`mem_rdata`, and bit k of `mem_be`.
- R4: The size codes are 0 = byte, 1 = halfword and 2 = word, so an access spans 2^size bytes starting at A. In mode 0, byte A+i is value byte i. In modes 1 to 3, byte A+i is value byte (2^size−1−i). Value byte j is bits 8j+7..8j.
- R5: For every valid request `mem_be` has exactly 2^size bits set. With `req_valid` low it is zero. Lanes of `mem_wdata` that are not enabled are zero, whatever the upper bits of `req_wdata` hold.
- R6: A word access at a word-aligned address enables the same lanes and gives the same lane data in mode 0 and in modes 2/3.
- R7: A read request (`req_valid` high, `req_write` low) raises `rsp_valid` for exactly the next cycle. In that cycle `rsp_rdata` is assembled from `mem_rdata` by the rules of R3/R4, and value bytes above the access size are zero. `rsp_rdata` is zero whenever `rsp_valid` is low.
- R8: The response uses the mode, address and size captured with the read request. Changes on those inputs in the response cycle have no effect on it.
- R9: Back-to-back reads of consecutive words (address +4 each) each return correctly, one per cycle, when every word uses the same model.
- R10: A write request produces no response: `rsp_valid` stays low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access presented this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_mode | input | 2 | Byte-order model code (R2) |
| req_addr | input | AW | Logical byte address |
| req_size | input | SZ_W | log2 of access bytes |
| req_wdata | input | DATA_W | Right-justified store value |
| mem_addr | output | AW | Word address to memory |
| mem_be | output | DATA_W/8 | Physical byte enables |
| mem_wdata | output | DATA_W | Lane-steered store data |
| mem_rdata | input | DATA_W | Physical word from memory, one cycle after a load |
| rsp_valid | output | 1 | Load value available |
| rsp_rdata | output | DATA_W | Assembled, zero-extended load value |

## Verification
The bench builds the block with a 32-bit data word (four lanes, two offset bits) and a 16-bit address. This keeps the lane XOR at 3 and lets a small physical memory model in the bench cover every lane and offset. With that width, halfwords at offsets 0, 1 and 2 and words at offset 0 can be checked in all four mode codes against hand-derived lane patterns. Store-then-load round trips across different models are also within reach with the same memory model.

// File: rtl/elm_pkg.sv
package elm_pkg;

    typedef enum logic [1:0] {
        ORD_LITTLE       = 2'd0,
        ORD_BIG_BYTE     = 2'd1,
        ORD_BIG_WORD     = 2'd2,
        ORD_BIG_WORD_ALT = 2'd3
    } byte_order_e;

    // Little-endian value combining only for code 0.
    function automatic logic order_is_little(input logic [1:0] m);
        return m == ORD_LITTLE;
    endfunction

    // Word-invariant models remap the lane index.
    function automatic logic order_flips_lane(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/elm_lane_plan.sv
module elm_lane_plan #(
    parameter int LANES = 4,
    parameter int OFF_W = 2,
    parameter int SZ_W  = 2
) (
    input  logic [1:0]             mode,
    input  logic [OFF_W-1:0]       off,
    input  logic [SZ_W-1:0]        size,
    output logic [LANES-1:0]       lane_en,
    output logic [LANES*OFF_W-1:0] lane_sig
);
    import elm_pkg::*;

    localparam logic [OFF_W-1:0] LANE_MAX = OFF_W'(LANES - 1);

    always_comb begin
        int               nbytes;
        logic [OFF_W-1:0] logical;
        logic [OFF_W-1:0] lane;
        logic [OFF_W-1:0] sig;
        lane_en  = '0;
        lane_sig = '0;
        logical  = '0;
        lane     = '0;
        sig      = '0;
        nbytes   = 1 << size;
        if (nbytes > LANES) nbytes = LANES;
        for (int i = 0; i < LANES; i++) begin
            if (i < nbytes) begin
                logical = off + OFF_W'(i);
                lane    = order_flips_lane(mode) ? (logical ^ LANE_MAX) : logical;
                sig     = order_is_little(mode) ? OFF_W'(i) : OFF_W'(nbytes - 1 - i);
                lane_en[lane]                  = 1'b1;
                lane_sig[lane*OFF_W +: OFF_W]  = sig;
            end
        end
    end

endmodule

// File: rtl/elm_wr_pack.sv
module elm_wr_pack #(
    parameter int LANES = 4,
    parameter int OFF_W = 2
) (
    input  logic [LANES-1:0]       lane_en,
    input  logic [LANES*OFF_W-1:0] lane_sig,
    input  logic [LANES*8-1:0]     value,
    output logic [LANES*8-1:0]     phys
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [OFF_W-1:0] sig;
        assign sig           = lane_sig[g*OFF_W +: OFF_W];
        assign phys[g*8 +: 8] = lane_en[g] ? value[sig*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/elm_rd_unpack.sv
module elm_rd_unpack #(
    parameter int LANES = 4,
    parameter int OFF_W = 2
) (
    input  logic [LANES-1:0]       lane_en,
    input  logic [LANES*OFF_W-1:0] lane_sig,
    input  logic [LANES*8-1:0]     phys,
    output logic [LANES*8-1:0]     value
);
    always_comb begin
        value = '0;
        for (int l = 0; l < LANES; l++) begin
            if (lane_en[l]) value[lane_sig[l*OFF_W +: OFF_W]*8 +: 8] = phys[l*8 +: 8];
        end
    end
endmodule

// File: rtl/endian_lane_mapper.sv
module endian_lane_mapper #(
    parameter int AW     = 32,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int SZ_W  = $clog2(OFF_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_mode,
    input  logic [AW-1:0]     req_addr,
    input  logic [SZ_W-1:0]   req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [AW-1:0]     mem_addr,
    output logic [LANES-1:0]  mem_be,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    typedef struct packed {
        logic                     rsp_valid;
        logic [LANES-1:0]         en;
        logic [LANES*OFF_W-1:0]   sig;
    } rd_ctx_t;

    rd_ctx_t ctx_d, ctx_q;

    logic [LANES-1:0]       plan_en;
    logic [LANES*OFF_W-1:0] plan_sig;
    logic [LANES-1:0]       req_en;
    logic [LANES-1:0]       rsp_en;
    logic                   rd_req;

    elm_lane_plan #(.LANES(LANES), .OFF_W(OFF_W), .SZ_W(SZ_W)) u_plan (
        .mode     (req_mode),
        .off      (req_addr[OFF_W-1:0]),
        .size     (req_size),
        .lane_en  (plan_en),
        .lane_sig (plan_sig)
    );

    assign rd_req   = req_valid && !req_write;
    assign req_en   = plan_en & {LANES{req_valid}};
    assign mem_be   = req_en;
    assign mem_addr = {req_addr[AW-1:OFF_W], {OFF_W{1'b0}}};

    elm_wr_pack #(.LANES(LANES), .OFF_W(OFF_W)) u_pack (
        .lane_en  (req_en),
        .lane_sig (plan_sig),
        .value    (req_wdata),
        .phys     (mem_wdata)
    );

    // Next-state: capture the lane plan of a load so the returning word
    // is decoded with the request's own model.
    always_comb begin
        ctx_d           = ctx_q;
        ctx_d.rsp_valid = rd_req;
        if (rd_req) begin
            ctx_d.en  = plan_en;
            ctx_d.sig = plan_sig;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctx_q <= '0;
        else        ctx_q <= ctx_d;
    end

    assign rsp_en    = ctx_q.en & {LANES{ctx_q.rsp_valid}};
    assign rsp_valid = ctx_q.rsp_valid;

    elm_rd_unpack #(.LANES(LANES), .OFF_W(OFF_W)) u_unpack (
        .lane_en  (rsp_en),
        .lane_sig (ctx_q.sig),
        .phys     (mem_rdata),
        .value    (rsp_rdata)
    );

endmodule

// File: rtl/elm_mapper_chk.sv
module elm_mapper_chk #(
    parameter int AW     = 32,
    parameter int DATA_W = 32,
    localparam int LANES = DATA_W / 8,
    localparam int OFF_W = $clog2(LANES),
    localparam int SZ_W  = $clog2(OFF_W + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [SZ_W-1:0]   req_size,
    input logic [AW-1:0]     mem_addr,
    input logic [LANES-1:0]  mem_be,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              rsp_valid,
    input logic [DATA_W-1:0] rsp_rdata
);
    logic [SZ_W-1:0]   rd_size_q;
    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] be_bits;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       rd_size_q <= '0;
        else if (req_valid && !req_write) rd_size_q <= req_size;
    end

    always_comb begin
        for (int b = 0; b < LANES; b++) begin
            keep_mask[b*8 +: 8] = (b < (1 << rd_size_q)) ? 8'hFF : 8'h00;
            be_bits[b*8 +: 8]   = {8{mem_be[b]}};
        end
    end

    a_r2_word_addr: assert property (@(posedge clk) disable iff (!rst_n)
        mem_addr[OFF_W-1:0] == '0);

    a_r5_be_count: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && int'(req_size) <= OFF_W) |-> $countones(mem_be) == (1 << req_size));

    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> mem_be == '0);

    a_r5_wdata_lanes: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wdata & ~be_bits) == '0);

    a_r7_rsp_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && req_valid && !req_write) |=> rsp_valid);

    a_r7_rsp_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> rsp_rdata == '0);

    a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_rdata & ~keep_mask) == '0);

    a_r10_no_rsp_after_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !(req_valid && !req_write)) |=> !rsp_valid);

endmodule

bind endian_lane_mapper elm_mapper_chk #(.AW(AW), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_size  (req_size),
    .mem_addr  (mem_addr),
    .mem_be    (mem_be),
    .mem_wdata (mem_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
);

// File: tb/tb_endian_lane_mapper.sv
`timescale 1ns/1ps
module tb_endian_lane_mapper;
    localparam int AW = 16;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_mode = 2'd0;
    logic [AW-1:0] req_addr = '0;
    logic [1:0]    req_size = 2'd0;
    logic [DW-1:0] req_wdata = '0;
    logic [AW-1:0] mem_addr;
    logic [3:0]    mem_be;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    endian_lane_mapper #(.AW(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_mode(req_mode), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata)
    );

    // Physical memory model: lane k = bits 8k+7..8k, one-cycle read.
    logic [31:0] pmem [16];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 16; i++) pmem[i] <= 32'h0;
            pmem[0] <= 32'h44332211;
            pmem[1] <= 32'h88776655;
        end else begin
            if (req_valid && !req_write) mem_rdata <= pmem[mem_addr[5:2]];
            if (req_valid && req_write)
                for (int b = 0; b < 4; b++)
                    if (mem_be[b]) pmem[mem_addr[5:2]][b*8 +: 8] <= mem_wdata[b*8 +: 8];
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic v, input logic w, input logic [1:0] m,
                       input logic [AW-1:0] a, input logic [1:0] s, input logic [31:0] d);
        req_valid = v; req_write = w; req_mode = m;
        req_addr = a; req_size = s; req_wdata = d;
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk("R1", "be in reset", {28'h0, mem_be}, 32'h0);
        chk("R1", "rsp_valid in reset", {31'h0, rsp_valid}, 32'h0);
        chk("R1", "rsp_rdata in reset", rsp_rdata, 32'h0);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1", "rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic t_read(input string req, input logic [1:0] m, input logic [AW-1:0] a,
                          input logic [1:0] s, input logic [3:0] exp_be, input logic [31:0] exp);
        @(negedge clk);
        put(1'b1, 1'b0, m, a, s, 32'hDEAD_BEEF);
        #1 chk(req, "read be", {28'h0, mem_be}, {28'h0, exp_be});
        @(negedge clk);
        put(1'b0, 1'b0, 2'd0, '0, 2'd0, 32'h0);
        #1 chk(req, "rsp_valid", {31'h0, rsp_valid}, 32'h1);
        chk(req, "rsp_rdata", rsp_rdata, exp);
    endtask

    task automatic t_write(input string req, input logic [1:0] m, input logic [AW-1:0] a,
                           input logic [1:0] s, input logic [31:0] d, input logic [AW-1:0] exp_addr,
                           input logic [3:0] exp_be, input logic [31:0] exp_wd);
        @(negedge clk);
        put(1'b1, 1'b1, m, a, s, d);
        #1 chk(req, "write addr", {16'h0, mem_addr}, {16'h0, exp_addr});
        chk(req, "write be", {28'h0, mem_be}, {28'h0, exp_be});
        chk(req, "write data", mem_wdata, exp_wd);
        @(negedge clk);
        put(1'b0, 1'b0, 2'd0, '0, 2'd0, 32'h0);
        #1 chk("R10", "no response after write", {31'h0, rsp_valid}, 32'h0);
    endtask

    task automatic t_lane_reads();
        t_read("R3", 2'd0, 16'h0001, 2'd0, 4'b0010, 32'h0000_0022);
        t_read("R3", 2'd1, 16'h0001, 2'd0, 4'b0010, 32'h0000_0022);
        t_read("R3", 2'd2, 16'h0001, 2'd0, 4'b0100, 32'h0000_0033);
        t_read("R3", 2'd2, 16'h0007, 2'd0, 4'b0001, 32'h0000_0055);
        t_read("R4", 2'd0, 16'h0000, 2'd1, 4'b0011, 32'h0000_2211);
        t_read("R4", 2'd1, 16'h0000, 2'd1, 4'b0011, 32'h0000_1122);
        t_read("R4", 2'd2, 16'h0000, 2'd1, 4'b1100, 32'h0000_4433);
        t_read("R4", 2'd2, 16'h0002, 2'd1, 4'b0011, 32'h0000_2211);
        t_read("R4", 2'd1, 16'h0001, 2'd1, 4'b0110, 32'h0000_2233);
        t_read("R4", 2'd1, 16'h0000, 2'd2, 4'b1111, 32'h1122_3344);
        t_read("R6", 2'd0, 16'h0000, 2'd2, 4'b1111, 32'h4433_2211);
        t_read("R6", 2'd2, 16'h0000, 2'd2, 4'b1111, 32'h4433_2211);
        @(negedge clk); #1;
        chk("R7", "rsp_rdata zero when idle", rsp_rdata, 32'h0);
    endtask

    task automatic t_lane_writes();
        t_write("R3", 2'd2, 16'h0020, 2'd0, 32'h1234_56AB, 16'h0020, 4'b1000, 32'hAB00_0000);
        t_write("R5", 2'd0, 16'h0021, 2'd1, 32'hFFFF_BEEF, 16'h0020, 4'b0110, 32'h00BE_EF00);
        t_write("R4", 2'd1, 16'h0021, 2'd1, 32'h0000_BEEF, 16'h0020, 4'b0110, 32'h00EF_BE00);
        t_write("R4", 2'd1, 16'h0024, 2'd2, 32'h1234_5678, 16'h0024, 4'b1111, 32'h7856_3412);
        t_write("R6", 2'd2, 16'h0024, 2'd2, 32'h1234_5678, 16'h0024, 4'b1111, 32'h1234_5678);
        t_write("R2", 2'd3, 16'h0013, 2'd0, 32'h0000_00C3, 16'h0010, 4'b0001, 32'h0000_00C3);
    endtask

    task automatic t_round_trip();
        t_write("R4", 2'd1, 16'h002A, 2'd1, 32'h0000_A1B2, 16'h0028, 4'b1100, 32'hB2A1_0000);
        t_read("R7", 2'd1, 16'h002A, 2'd1, 4'b1100, 32'h0000_A1B2);
        t_read("R7", 2'd0, 16'h002A, 2'd1, 4'b1100, 32'h0000_B2A1);
        t_read("R7", 2'd2, 16'h0028, 2'd1, 4'b1100, 32'h0000_B2A1);
        t_read("R7", 2'd0, 16'h0028, 2'd2, 4'b1111, 32'hB2A1_0000);
    endtask

    task automatic t_mode_hold();
        @(negedge clk);
        put(1'b1, 1'b0, 2'd1, 16'h0000, 2'd2, 32'h0);
        @(negedge clk);
        put(1'b1, 1'b1, 2'd0, 16'h003D, 2'd0, 32'h0000_0077);
        #1 chk("R8", "rsp_valid", {31'h0, rsp_valid}, 32'h1);
        chk("R8", "rsp uses captured mode", rsp_rdata, 32'h1122_3344);
        @(negedge clk);
        put(1'b0, 1'b0, 2'd0, '0, 2'd0, 32'h0);
    endtask

    task automatic t_burst(input logic [1:0] m, input logic [31:0] exp0, input logic [31:0] exp1);
        @(negedge clk);
        put(1'b1, 1'b0, m, 16'h0000, 2'd2, 32'h0);
        @(negedge clk);
        put(1'b1, 1'b0, m, 16'h0004, 2'd2, 32'h0);
        #1 chk("R9", "first word", rsp_rdata, exp0);
        @(negedge clk);
        put(1'b0, 1'b0, 2'd0, '0, 2'd0, 32'h0);
        #1 chk("R9", "second word valid", {31'h0, rsp_valid}, 32'h1);
        chk("R9", "second word", rsp_rdata, exp1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_lane_reads();
        t_lane_writes();
        t_round_trip();
        t_mode_hold();
        t_burst(2'd1, 32'h1122_3344, 32'h5566_7788);
        t_burst(2'd2, 32'h4433_2211, 32'h8877_6655);
        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule